// File: doc/BRIEF.md
# Power-On Interface Mode Selector

This block settles, once per power cycle, which host protocol a removable storage device speaks: the native 68-pin parallel protocol or a PC-card-compatible one. After power-good rises it waits out a guard interval of about 19 ms. During that interval every host line except the active-low mode-select pin is held off from the device core. On the final edge of the interval the synchronised select pin is sampled a single time, and the result is latched.

Neither a hardware reset nor a software reset reopens the decision. Only loss of power-good does. A device latched into native mode whose select line later drops disables itself until power is removed. Downstream logic sees a 2-bit mode code, a disable flag and a gated, active-high copy of the host strobes, address and device-select. The device-select comes from either the cable-select pin or the inverted master/slave pin. Only one of the two chip-select-1 pins is honoured.

Top module: `ifmode_select`

## Requirements
- R1: After power-good rises, mode_o stays 00 (waiting) and the guard decides the mode on exactly the GUARD_CYC-th rising clock edge with power-good high, where GUARD_CYC = CLK_HZ/1e6 * GUARD_US.
- R2: If the synchronised select (active low) is low on the deciding edge, mode_o becomes 01 (native 68-pin).
- R3: If the select is high on the deciding edge, mode_o becomes 10 (PC-card) when PC_FALLBACK=1, or 11 (disabled, no response) when PC_FALLBACK=0.
- R4: In mode 10, later changes of the select line have no effect on mode_o.
- R5: In mode 01, a negation of the select line drives mode_o to 11 on the third rising edge after the change (two-flop synchroniser plus the mode register), and disabled_o is high whenever mode_o is 11.
- R6: Mode 11 holds until power-good goes low. Power-good low returns mode_o to 00 on the next edge and restarts the guard from zero.
- R7: The host hardware reset (hrst_ni) and the software reset request (sw_rst_i) never change mode_o, whether they arrive during the guard or after the decision.
- R8: In modes 01 and 10 the gated outputs are active-high copies of the host lines (cs0_o = !cs0_ni, rd_o, wr_o, hrst_o likewise, srst_o = sw_rst_i, addr_o = addr_i). In modes 00 and 11 all gated outputs are 0.
- R9: With USE_CSEL=1, dev_sel_o follows csel_i and msel_ni is ignored. With USE_CSEL=0, dev_sel_o = !msel_ni. In both cases the output is subject to the gating of R8.
- R10: Only the chip-select-1 pin chosen by CS1_PIN (0 = cs1a_ni, 1 = cs1b_ni) drives cs1_o. The other pin is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block's flops |
| pwr_good_i | input | 1 | Supply within tolerance; low means power removed |
| sel_ni | input | 1 | Mode-select pin, active low = native mode |
| hrst_ni | input | 1 | Host hardware reset, active low |
| sw_rst_i | input | 1 | Software reset request from the core |
| cs0_ni | input | 1 | Host chip-select 0, active low |
| cs1a_ni | input | 1 | First chip-select-1 pin, active low |
| cs1b_ni | input | 1 | Second chip-select-1 pin, active low |
| rd_ni | input | 1 | Host read strobe, active low |
| wr_ni | input | 1 | Host write strobe, active low |
| addr_i | input | 3 | Host register address |
| csel_i | input | 1 | Cable-select level |
| msel_ni | input | 1 | Master/slave pin, inverse of cable-select |
| mode_o | output | 2 | 00 waiting, 01 native, 10 PC-card, 11 disabled |
| disabled_o | output | 1 | High in mode 11 |
| dev_sel_o | output | 1 | Gated device-select bit |
| cs0_o | output | 1 | Gated chip-select 0, active high |
| cs1_o | output | 1 | Gated chip-select 1, active high |
| rd_o | output | 1 | Gated read strobe, active high |
| wr_o | output | 1 | Gated write strobe, active high |
| hrst_o | output | 1 | Gated hardware reset, active high |
| srst_o | output | 1 | Gated software reset, active high |
| addr_o | output | 3 | Gated address |

## Verification
Power-good and the select level are driven one time unit after a rising edge. The mode is therefore sampled one cycle before the GUARD_CYC-th edge, where it must still be 00, and again right after that edge, where it must be decided. A select drop in native mode needs three edges to reach mode_o, so the bench confirms the mode is unchanged after two edges and reads 11 after the third. Power-good loss shows on the following edge. The gated outputs are combinational from the mode register and the pins, so they are checked in the same sample as the mode.

// File: rtl/ifmode_pkg.sv
package ifmode_pkg;
  typedef enum logic [1:0] {
    MODE_WAIT   = 2'b00,
    MODE_NATIVE = 2'b01,
    MODE_PCCARD = 2'b10,
    MODE_OFF    = 2'b11
  } mode_t;
endpackage

// File: rtl/ifmode_sync.sv
module ifmode_sync #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RESET_VAL;
      s2_q <= RESET_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ifmode_guard.sv
module ifmode_guard #(
  parameter int unsigned GUARD_CYC = 3800000,
  localparam int unsigned CNT_W = $clog2(GUARD_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  output logic expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign expire_o = pwr_good_i && !done_q && (cnt_q == CNT_W'(GUARD_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!pwr_good_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (expire_o) begin
      done_q <= 1'b1;
    end else if (!done_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_expire_once_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);

  p_done_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && done_q) |=> (done_q || !pwr_good_i) && !expire_o);

  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> (cnt_q == '0) && !done_q);
endmodule

// File: rtl/ifmode_fsm.sv
module ifmode_fsm
  import ifmode_pkg::*;
#(
  parameter bit PC_FALLBACK = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pwr_good_i,
  input  logic  expire_i,
  input  logic  sel_n_i,
  output mode_t mode_o
);
  localparam mode_t FALLBACK = PC_FALLBACK ? MODE_PCCARD : MODE_OFF;

  mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_WAIT;
    end else if (!pwr_good_i) begin
      mode_q <= MODE_WAIT;
    end else begin
      case (mode_q)
        MODE_WAIT:   if (expire_i) mode_q <= sel_n_i ? FALLBACK : MODE_NATIVE;
        MODE_NATIVE: if (sel_n_i) mode_q <= MODE_OFF;
        default:     mode_q <= mode_q;
      endcase
    end
  end

  assign mode_o = mode_q;

  p_hold_wait_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_WAIT && !expire_i) |=> mode_q == MODE_WAIT);

  p_pick_native_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && expire_i && !sel_n_i) |=> mode_q == MODE_NATIVE);

  p_pick_fallback_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && expire_i && sel_n_i) |=> mode_q == FALLBACK);

  p_pc_stays_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && mode_q == MODE_PCCARD) |=> mode_q == MODE_PCCARD);

  p_native_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && mode_q == MODE_NATIVE && sel_n_i) |=> mode_q == MODE_OFF);

  p_off_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && mode_q == MODE_OFF) |=> mode_q == MODE_OFF);

  p_power_loss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> mode_q == MODE_WAIT);
endmodule

// File: rtl/ifmode_select.sv
module ifmode_select
  import ifmode_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 200000000,
  parameter int unsigned GUARD_US    = 19000,
  parameter bit          PC_FALLBACK = 1'b1,
  parameter bit          USE_CSEL    = 1'b1,
  parameter bit          CS1_PIN     = 1'b0,
  parameter int unsigned ADDR_W      = 3,
  localparam int unsigned GUARD_CYC  = (CLK_HZ / 1000000) * GUARD_US
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic              sel_ni,
  input  logic              hrst_ni,
  input  logic              sw_rst_i,
  input  logic              cs0_ni,
  input  logic              cs1a_ni,
  input  logic              cs1b_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              csel_i,
  input  logic              msel_ni,
  output logic [1:0]        mode_o,
  output logic              disabled_o,
  output logic              dev_sel_o,
  output logic              cs0_o,
  output logic              cs1_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              hrst_o,
  output logic              srst_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic  sel_n_sync;
  logic  expire;
  mode_t mode;
  logic  live;
  logic  cs1_n_pick;
  logic  dev_raw;

  ifmode_sync #(.RESET_VAL(1'b1)) u_sel_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sel_ni),
    .q_o    (sel_n_sync)
  );

  ifmode_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_good_i (pwr_good_i),
    .expire_o   (expire)
  );

  ifmode_fsm #(.PC_FALLBACK(PC_FALLBACK)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_good_i (pwr_good_i),
    .expire_i   (expire),
    .sel_n_i    (sel_n_sync),
    .mode_o     (mode)
  );

  generate
    if (CS1_PIN) begin : g_cs1_b
      assign cs1_n_pick = cs1b_ni;
    end else begin : g_cs1_a
      assign cs1_n_pick = cs1a_ni;
    end
    if (USE_CSEL) begin : g_dev_csel
      assign dev_raw = csel_i;
    end else begin : g_dev_msel
      assign dev_raw = ~msel_ni;
    end
  endgenerate

  // host lines reach the core only in a decided, working mode
  assign live       = (mode == MODE_NATIVE) || (mode == MODE_PCCARD);
  assign mode_o     = mode;
  assign disabled_o = (mode == MODE_OFF);
  assign cs0_o      = live & ~cs0_ni;
  assign cs1_o      = live & ~cs1_n_pick;
  assign rd_o       = live & ~rd_ni;
  assign wr_o       = live & ~wr_ni;
  assign hrst_o     = live & ~hrst_ni;
  assign srst_o     = live & sw_rst_i;
  assign dev_sel_o  = live & dev_raw;
  assign addr_o     = live ? addr_i : '0;

  p_gate_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_WAIT || mode_o == MODE_OFF) |->
      !(cs0_o || cs1_o || rd_o || wr_o || hrst_o || srst_o || dev_sel_o) && addr_o == '0);

  p_off_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disabled_o == (mode_o == MODE_OFF));
endmodule

// File: tb/ifmode_select_tb.sv
`timescale 1ns/100ps
module ifmode_select_tb;
  localparam int unsigned CLK_HZ   = 200000000;
  localparam int unsigned GUARD_US = 19;
  localparam int unsigned GCYC     = (CLK_HZ / 1000000) * GUARD_US;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_ni, pwr_good, sel_ni, hrst_ni, sw_rst, cs0_ni, cs1a_ni, cs1b_ni;
  logic rd_ni, wr_ni, csel, msel_ni;
  logic [2:0] addr;
  logic [1:0] mode, mode_q;
  logic disabled, dev_sel, cs0, cs1, rd, wr, hrst, srst;
  logic disabled_q, dev_sel_q, cs0_q, cs1_q, rd_q, wr_q, hrst_q, srst_q;
  logic [2:0] addr_o, addr_q;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  ifmode_select #(.CLK_HZ(CLK_HZ), .GUARD_US(GUARD_US), .PC_FALLBACK(1'b1),
                  .USE_CSEL(1'b1), .CS1_PIN(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_good_i(pwr_good), .sel_ni(sel_ni),
    .hrst_ni(hrst_ni), .sw_rst_i(sw_rst), .cs0_ni(cs0_ni), .cs1a_ni(cs1a_ni),
    .cs1b_ni(cs1b_ni), .rd_ni(rd_ni), .wr_ni(wr_ni), .addr_i(addr),
    .csel_i(csel), .msel_ni(msel_ni), .mode_o(mode), .disabled_o(disabled),
    .dev_sel_o(dev_sel), .cs0_o(cs0), .cs1_o(cs1), .rd_o(rd), .wr_o(wr),
    .hrst_o(hrst), .srst_o(srst), .addr_o(addr_o));

  // silent-fallback build, master/slave pin, second cs1 pin
  ifmode_select #(.CLK_HZ(CLK_HZ), .GUARD_US(GUARD_US), .PC_FALLBACK(1'b0),
                  .USE_CSEL(1'b0), .CS1_PIN(1'b1)) u_dut_q (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_good_i(pwr_good), .sel_ni(sel_ni),
    .hrst_ni(hrst_ni), .sw_rst_i(sw_rst), .cs0_ni(cs0_ni), .cs1a_ni(cs1a_ni),
    .cs1b_ni(cs1b_ni), .rd_ni(rd_ni), .wr_ni(wr_ni), .addr_i(addr),
    .csel_i(csel), .msel_ni(msel_ni), .mode_o(mode_q), .disabled_o(disabled_q),
    .dev_sel_o(dev_sel_q), .cs0_o(cs0_q), .cs1_o(cs1_q), .rd_o(rd_q), .wr_o(wr_q),
    .hrst_o(hrst_q), .srst_o(srst_q), .addr_o(addr_q));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_host();
    hrst_ni = 1'b1; sw_rst = 1'b0; cs0_ni = 1'b1; cs1a_ni = 1'b1; cs1b_ni = 1'b1;
    rd_ni = 1'b1; wr_ni = 1'b1; addr = 3'd0; csel = 1'b0; msel_ni = 1'b1;
  endtask

  task automatic power_up(input logic sel);
    pwr_good = 1'b0;
    tick(2);
    chk("R6", "mode after power loss", mode, 2'b00);
    sel_ni = sel;
    tick(3);
    pwr_good = 1'b1;
  endtask

  task automatic t_reset_state();
    chk("R1", "mode at reset", mode, 2'b00);
    chk("R8", "cs0 at reset", cs0, 1'b0);
    chk("R5", "disabled at reset", disabled, 1'b0);
  endtask

  task automatic t_native();
    power_up(1'b0);
    cs0_ni = 1'b0; rd_ni = 1'b0; addr = 3'd5; csel = 1'b1;
    tick(100);
    hrst_ni = 1'b0; sw_rst = 1'b1;
    tick(10);
    chk("R8", "hrst gated in guard", hrst, 1'b0);
    chk("R8", "srst gated in guard", srst, 1'b0);
    hrst_ni = 1'b1; sw_rst = 1'b0;
    tick(GCYC - 111);
    chk("R1", "mode one edge before expiry", mode, 2'b00);
    chk("R7", "resets did not shift guard", mode, 2'b00);
    chk("R8", "cs0 gated in guard", cs0, 1'b0);
    chk("R8", "addr gated in guard", addr_o, 3'd0);
    chk("R9", "dev_sel gated in guard", dev_sel, 1'b0);
    tick(1);
    chk("R1", "mode on expiry edge", mode, 2'b01);
    chk("R2", "native selected", mode, 2'b01);
    chk("R2", "native in second build", mode_q, 2'b01);
    chk("R8", "cs0 live", cs0, 1'b1);
    chk("R8", "rd live", rd, 1'b1);
    chk("R8", "wr idle", wr, 1'b0);
    chk("R8", "addr live", addr_o, 3'd5);
    chk("R9", "dev_sel from csel", dev_sel, 1'b1);
    chk("R9", "dev_sel_q from msel high", dev_sel_q, 1'b0);
    msel_ni = 1'b0;
    tick(1);
    chk("R9", "msel ignored by csel build", dev_sel, 1'b1);
    chk("R9", "dev_sel_q from msel low", dev_sel_q, 1'b1);
    csel = 1'b0;
    tick(1);
    chk("R9", "dev_sel follows csel low", dev_sel, 1'b0);
    cs1a_ni = 1'b0;
    tick(1);
    chk("R10", "cs1 pin a honoured", cs1, 1'b1);
    chk("R10", "cs1 pin a ignored by b build", cs1_q, 1'b0);
    cs1a_ni = 1'b1; cs1b_ni = 1'b0;
    tick(1);
    chk("R10", "cs1 pin b ignored", cs1, 1'b0);
    chk("R10", "cs1 pin b honoured by b build", cs1_q, 1'b1);
    cs1b_ni = 1'b1;
    hrst_ni = 1'b0; sw_rst = 1'b1; wr_ni = 1'b0;
    tick(5);
    chk("R7", "native kept through resets", mode, 2'b01);
    chk("R8", "hrst passed", hrst, 1'b1);
    chk("R8", "srst passed", srst, 1'b1);
    chk("R8", "wr passed", wr, 1'b1);
    idle_host();
    tick(2);
    chk("R7", "native after reset release", mode, 2'b01);
  endtask

  task automatic t_pccard();
    power_up(1'b1);
    cs0_ni = 1'b0;
    tick(GCYC - 1);
    chk("R1", "waiting before expiry", mode, 2'b00);
    tick(1);
    chk("R3", "pc-card fallback", mode, 2'b10);
    chk("R3", "silent fallback build", mode_q, 2'b11);
    chk("R8", "cs0 live in pc-card", cs0, 1'b1);
    chk("R8", "cs0 gated in silent build", cs0_q, 1'b0);
    chk("R5", "silent build flags disabled", disabled_q, 1'b1);
    sel_ni = 1'b0;
    tick(6);
    chk("R4", "select assert ignored", mode, 2'b10);
    sel_ni = 1'b1;
    tick(6);
    chk("R4", "select negate ignored", mode, 2'b10);
    hrst_ni = 1'b0; sw_rst = 1'b1;
    tick(4);
    chk("R7", "pc-card kept through resets", mode, 2'b10);
    idle_host();
  endtask

  task automatic t_drop();
    power_up(1'b0);
    tick(GCYC);
    chk("R2", "native before drop", mode, 2'b01);
    sel_ni = 1'b1;
    tick(2);
    chk("R5", "still native two edges after drop", mode, 2'b01);
    tick(1);
    chk("R5", "disabled third edge after drop", mode, 2'b11);
    chk("R5", "disabled flag", disabled, 1'b1);
    sel_ni = 1'b0; cs0_ni = 1'b0; rd_ni = 1'b0;
    tick(6);
    chk("R6", "disabled sticky after reselect", mode, 2'b11);
    chk("R8", "cs0 gated when disabled", cs0, 1'b0);
    chk("R8", "rd gated when disabled", rd, 1'b0);
    hrst_ni = 1'b0; sw_rst = 1'b1;
    tick(4);
    chk("R7", "disabled kept through resets", mode, 2'b11);
    chk("R8", "hrst gated when disabled", hrst, 1'b0);
    idle_host();
    pwr_good = 1'b0;
    tick(1);
    chk("R6", "power loss clears disable", mode, 2'b00);
    chk("R6", "flag cleared", disabled, 1'b0);
    power_up(1'b0);
    tick(GCYC - 1);
    chk("R6", "guard restarted from zero", mode, 2'b00);
    tick(1);
    chk("R6", "native after power cycle", mode, 2'b01);
  endtask

  initial begin
    rst_ni = 1'b0; pwr_good = 1'b0; sel_ni = 1'b0;
    idle_host();
    tick(3);
    t_reset_state();
    rst_ni = 1'b1;
    tick(2);
    t_native();
    t_pccard();
    t_drop();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule